// File: doc/BRIEF.md
# DRAM Write Leveling Feedback Responder

This block models the memory side of write leveling in synthesizable form. While its leveling-mode bit is set, it watches the incoming data strobe pair. On each strobe rising edge it takes a snapshot of the clock level. After a programmable output delay, it reports that snapshot on one designated data line, called the prime line. The other data lines are first held at a placeholder level. A second programmable delay after the first report, they are pulled LOW. An output-disable bit keeps every data line undriven. Any command other than a no-operation or a deselect raises a sticky protocol error.

The clock level, the strobe pair and the command are all sampled on a fast system clock `clk`. Output timing is therefore counted in `clk` cycles. High-Z is represented as `dq_oe` LOW with `dq` forced to zero. The block is meant to be the self-checking partner of a leveling sequencer on the controller side. The sequencer sweeps its strobe delay and reads back the prime line.

Top module: `wl_responder`

## Requirements
- R1: During and right after synchronous reset, `dq_oe`, `dq`, `dq_undef` and `proto_err` are all 0.
- R2: One cycle after `lvl_en` is seen at 1 with `out_off` at 0, `dq_oe` is 1. Until the first report, `dq` is all ones and `dq_undef` is 1.
- R3: A capture happens only on a cycle where `dqs` rises from 0 to 1 while `dqs_n` falls from 1 to 0. A `dqs` rise with `dqs_n` staying at 1 captures nothing.
- R4: The clock level sampled on the capture cycle appears on `dq[PRIME]` exactly `WLO` cycles after that cycle. In the cycle before, the line still holds its old value. `dq_undef` falls with the first report.
- R5: Every non-prime line stays 1 until `WLOE` cycles after the first report, then reads 0 for the rest of the leveling session.
- R6: While `out_off` is 1, `dq_oe` is 0 and `dq` is 0 from the next cycle on. Captures still take place and show once `out_off` returns to 0.
- R7: One cycle after `lvl_en` drops, `dq_oe` and `dq` are 0. All capture state is cleared, so re-entry shows the undefined placeholder again.
- R8: The command is {cs_n, ras_n, cas_n, we_n}. A command with cs_n=1 (deselect) or equal to 4'b0111 (no-operation) is legal. In leveling mode, any other code sets `proto_err` on the next cycle. The flag stays set until `lvl_en` drops, and is never set outside the mode.
- R9: Each later capture replaces the prime value, so a series of strobe toggles reproduces the series of sampled clock levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_en | input | 1 | Leveling-mode bit |
| out_off | input | 1 | Output-disable bit |
| cmd | input | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| ck_level | input | 1 | Sampled level of the memory clock |
| dqs | input | 1 | Data strobe, true side |
| dqs_n | input | 1 | Data strobe, complement side |
| dq | output | DQ_W | Data lines (zero while undriven) |
| dq_oe | output | 1 | Data output enable |
| dq_undef | output | 1 | Placeholder value is being driven |
| proto_err | output | 1 | Illegal command seen in leveling mode |

## Verification
A corrupted capture register or delay stage shows on `dq[PRIME]` at exactly `WLO` cycles after the faulty strobe edge. The bench checks both that cycle and the one before it. A wrong non-prime counter moves the LOW transition of the other lines off the cycle `WLOE` after the first report. A state that is not flushed on exit shows up on re-entry as a missing `dq_undef`. Sweeping every 4-step clock pattern and all sixteen command codes exposes a faulty value or decode within one session.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef logic [3:0] wl_cmd_t; // {cs_n, ras_n, cas_n, we_n}

  localparam wl_cmd_t CMD_NOP = 4'b0111;

  function automatic logic cmd_legal(input wl_cmd_t c);
    return c[3] || (c == CMD_NOP);
  endfunction
endpackage

// File: rtl/wl_dqs_capture.sv
module wl_dqs_capture (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic dqs,
  input  logic dqs_n,
  input  logic ck_level,
  output logic cap_vld,
  output logic cap_val
);
  logic dqs_q, dqsn_q;
  logic rise;

  // true side rises while the complement falls
  assign rise = dqs && !dqs_q && !dqs_n && dqsn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dqs_q   <= 1'b0;
      dqsn_q  <= 1'b1;
      cap_vld <= 1'b0;
      cap_val <= 1'b0;
    end else begin
      dqs_q   <= dqs;
      dqsn_q  <= dqs_n;
      cap_vld <= mode && rise;
      if (mode && rise) cap_val <= ck_level;
    end
  end
endmodule

// File: rtl/wl_out_delay.sv
module wl_out_delay #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic in_vld,
  input  logic in_val,
  output logic out_vld,
  output logic out_val
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign out_vld = in_vld;
      assign out_val = in_val;
    end else begin : g_pipe
      logic [DEPTH-1:0] vld_sr;
      logic [DEPTH-1:0] val_sr;
      always_ff @(posedge clk) begin
        if (rst || flush) begin
          vld_sr <= '0;
          val_sr <= '0;
        end else begin
          vld_sr[0] <= in_vld;
          val_sr[0] <= in_val;
          for (int i = 1; i < DEPTH; i++) begin
            vld_sr[i] <= vld_sr[i-1];
            val_sr[i] <= val_sr[i-1];
          end
        end
      end
      assign out_vld = vld_sr[DEPTH-1];
      assign out_val = val_sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/wl_lane_ctrl.sv
module wl_lane_ctrl #(
  parameter int WLOE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic hit_vld,
  input  logic hit_val,
  output logic prime_q,
  output logic seen_q,
  output logic np_low_q
);
  localparam int CW = (WLOE > 1) ? $clog2(WLOE) : 1;
  localparam logic [CW-1:0] LAST = CW'(WLOE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !mode) begin
      prime_q  <= 1'b0;
      seen_q   <= 1'b0;
      np_low_q <= 1'b0;
      cnt      <= '0;
    end else begin
      if (hit_vld) begin
        prime_q <= hit_val;
        seen_q  <= 1'b1;
      end
      if (seen_q && !np_low_q) begin
        if (cnt == LAST) np_low_q <= 1'b1;
        else             cnt      <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wl_responder.sv
module wl_responder #(
  parameter int DQ_W  = 8,
  parameter int PRIME = 0,
  parameter int WLO   = 3,
  parameter int WLOE  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lvl_en,
  input  logic            out_off,
  input  logic [3:0]      cmd,
  input  logic            ck_level,
  input  logic            dqs,
  input  logic            dqs_n,
  output logic [DQ_W-1:0] dq,
  output logic            dq_oe,
  output logic            dq_undef,
  output logic            proto_err
);
  import wl_pkg::*;

  localparam int PIPE = WLO - 1;

  logic cap_vld, cap_val;
  logic hit_vld, hit_val;
  logic prime_q, seen_q, np_low_q;
  logic oe_q, err_q;

  wl_dqs_capture u_cap (
    .clk(clk), .rst(rst), .mode(lvl_en),
    .dqs(dqs), .dqs_n(dqs_n), .ck_level(ck_level),
    .cap_vld(cap_vld), .cap_val(cap_val)
  );

  wl_out_delay #(.DEPTH(PIPE)) u_dly (
    .clk(clk), .rst(rst), .flush(!lvl_en),
    .in_vld(cap_vld), .in_val(cap_val),
    .out_vld(hit_vld), .out_val(hit_val)
  );

  wl_lane_ctrl #(.WLOE(WLOE)) u_lane (
    .clk(clk), .rst(rst), .mode(lvl_en),
    .hit_vld(hit_vld), .hit_val(hit_val),
    .prime_q(prime_q), .seen_q(seen_q), .np_low_q(np_low_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      oe_q <= lvl_en && !out_off;
      if (!lvl_en)             err_q <= 1'b0;
      else if (!cmd_legal(cmd)) err_q <= 1'b1;
    end
  end

  generate
    for (genvar b = 0; b < DQ_W; b++) begin : g_lane
      if (b == PRIME) begin : g_prime
        assign dq[b] = oe_q && (seen_q ? prime_q : 1'b1);
      end else begin : g_other
        assign dq[b] = oe_q && !np_low_q;
      end
    end
  endgenerate

  assign dq_oe     = oe_q;
  assign dq_undef  = oe_q && !seen_q;
  assign proto_err = err_q;
endmodule

// File: rtl/wl_responder_chk.sv
module wl_responder_chk #(
  parameter int DQ_W  = 8,
  parameter int PRIME = 0
) (
  input logic            clk,
  input logic            rst,
  input logic            lvl_en,
  input logic            out_off,
  input logic [3:0]      cmd,
  input logic [DQ_W-1:0] dq,
  input logic            dq_oe,
  input logic            dq_undef,
  input logic            proto_err
);
  localparam logic [DQ_W-1:0] NP_MASK = ~(DQ_W'(1) << PRIME);

  logic legal;
  assign legal = cmd[3] || (cmd == 4'b0111);

  a_r2_oe_on: assert property (@(posedge clk) disable iff (rst)
    (lvl_en && !out_off) |=> dq_oe);

  a_r2_undef_ones: assert property (@(posedge clk) disable iff (rst)
    dq_undef |-> (dq_oe && dq == '1));

  a_r6_qoff: assert property (@(posedge clk) disable iff (rst)
    out_off |=> !dq_oe);

  a_r6_hiz_zero: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> (dq == '0 && !dq_undef));

  a_r7_exit: assert property (@(posedge clk) disable iff (rst)
    !lvl_en |=> (!dq_oe && !proto_err));

  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err) |-> $past(lvl_en && !legal));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (proto_err && lvl_en) |=> proto_err);

  a_r5_np_hold: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && !dq_undef && (dq & NP_MASK) == '0 && lvl_en && !out_off)
      |=> ((dq & NP_MASK) == '0));
endmodule

bind wl_responder wl_responder_chk #(.DQ_W(DQ_W), .PRIME(PRIME)) u_chk (
  .clk(clk), .rst(rst), .lvl_en(lvl_en), .out_off(out_off), .cmd(cmd),
  .dq(dq), .dq_oe(dq_oe), .dq_undef(dq_undef), .proto_err(proto_err)
);

// File: tb/wl_responder_tb.sv
module wl_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DQ_W  = 8;
  localparam int PRIME = 0;
  localparam int WLO   = 3;
  localparam int WLOE  = 2;
  localparam logic [DQ_W-1:0] NP_MASK = ~(DQ_W'(1) << PRIME);

  logic clk = 0, rst = 1, lvl_en = 0, out_off = 0, ck_level = 0, dqs = 0, dqs_n = 1;
  logic [3:0] cmd = 4'b0111;
  logic [DQ_W-1:0] dq;
  logic dq_oe, dq_undef, proto_err;
  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wl_responder #(.DQ_W(DQ_W), .PRIME(PRIME), .WLO(WLO), .WLOE(WLOE)) u_dut (
    .clk(clk), .rst(rst), .lvl_en(lvl_en), .out_off(out_off), .cmd(cmd),
    .ck_level(ck_level), .dqs(dqs), .dqs_n(dqs_n),
    .dq(dq), .dq_oe(dq_oe), .dq_undef(dq_undef), .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic enter();
    @(negedge clk); lvl_en = 1; tick();
  endtask

  task automatic leave();
    @(negedge clk); lvl_en = 0; tick();
  endtask

  // one strobe toggle; checks prime timing. first=1 means no report yet.
  task automatic pulse(input logic ckv, input logic old, input bit first, input bit look);
    @(negedge clk); dqs = 1; dqs_n = 0; ck_level = ckv;
    @(posedge clk);                       // capture cycle
    @(negedge clk); dqs = 0; dqs_n = 1; ck_level = ~ckv;
    repeat (WLO-1) tick();
    if (look) begin
      if (first) chk("R4 undef before first report", dq_undef, 1);
      else       chk("R4 prime holds old value", dq[PRIME], old);
    end
    tick();
    if (look) begin
      chk("R4/R9 prime shows captured level", dq[PRIME], ckv);
      chk("R4 undef cleared", dq_undef, 0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 oe in reset", dq_oe, 0);
    chk("R1 dq in reset", dq, 0);
    @(negedge clk); rst = 0; tick();
    chk("R1 oe after reset", dq_oe, 0);
    chk("R1 undef after reset", dq_undef, 0);
    chk("R1 err after reset", proto_err, 0);

    // R2 / R3 / R5
    enter();
    chk("R2 oe on entry", dq_oe, 1);
    chk("R2 placeholder", dq, {DQ_W{1'b1}});
    chk("R2 undef on entry", dq_undef, 1);
    @(negedge clk); dqs = 1; dqs_n = 1;  // rise without complement fall
    repeat (WLO+2) tick();
    chk("R3 no capture without dqs_n fall", dq_undef, 1);
    @(negedge clk); dqs = 0; dqs_n = 1; tick();
    pulse(1'b1, 1'b0, 1, 1);
    chk("R5 non-prime still high at report", dq & NP_MASK, NP_MASK);
    repeat (WLOE-1) tick();
    chk("R5 non-prime high before WLOE", dq & NP_MASK, NP_MASK);
    tick();
    chk("R5 non-prime low after WLOE", dq & NP_MASK, 0);

    // R6
    @(negedge clk); out_off = 1; tick();
    chk("R6 oe off", dq_oe, 0);
    chk("R6 dq zero", dq, 0);
    pulse(1'b0, 1'b1, 0, 0);
    chk("R6 still off", dq_oe, 0);
    @(negedge clk); out_off = 0; tick();
    chk("R6 oe back", dq_oe, 1);
    chk("R6 capture kept while off", dq[PRIME], 0);
    chk("R6 non-prime low", dq & NP_MASK, 0);

    // R7
    leave();
    chk("R7 oe off on exit", dq_oe, 0);
    chk("R7 dq zero on exit", dq, 0);
    enter();
    chk("R7 undef again on re-entry", dq_undef, 1);
    leave();

    // R9: all 4-step clock patterns
    for (int p = 0; p < 16; p++) begin
      logic prev;
      enter();
      prev = 1'b0;
      for (int s = 0; s < 4; s++) begin
        logic b;
        b = p[s];
        pulse(b, prev, s == 0, 1);
        prev = b;
      end
      chk("R9 final pattern bit", dq[PRIME], p[3]);
      leave();
    end

    // R8: all command codes
    for (int c = 0; c < 16; c++) begin
      logic lg;
      lg = (c[3] == 1'b1) || (c == 7);
      @(negedge clk); cmd = 4'(c); tick();
      chk("R8 no error outside mode", proto_err, 0);
      @(negedge clk); cmd = 4'b0111; lvl_en = 1; tick();
      @(negedge clk); cmd = 4'(c); tick();
      chk("R8 error on illegal code", proto_err, !lg);
      @(negedge clk); cmd = 4'b1111; tick();
      chk("R8 error sticky", proto_err, !lg);
      leave();
      chk("R8 error cleared on exit", proto_err, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule